// File: doc/BRIEF.md
# Stack-Gated Interrupt Acknowledge Controller

This block decides when a small microcontroller core may take an interrupt. It serves one external interrupt source and a configurable number of timer or event-counter sources. It keeps a single control register that holds three kinds of bits:

- a master enable;
- one enable bit per source;
- one latched request flag per source.

Whenever the master enable is set and some enabled request is pending, the block raises an acknowledge. It raises it in the same cycle, but only if the return stack still has room. Alongside the acknowledge it gives a one-hot select naming the winning source, and the core's sequencer uses that select to pick the vector.

Taking an interrupt clears the master enable and the flag of the source that was served. Further interrupts therefore wait until software sets the master enable again. Requests that arrive in the meantime are still recorded in their flags. The block also drives a wake-up line for halt mode. That line reflects any enabled pending request, whatever the state of the master enable and the stack.

Top module: `irq_gate`

## Requirements
- R1: After reset the control register reads all zero, and `ack`, `ack_sel` and `wake` are low.
- R2: A high bit of `src_evt` sets the matching request flag at the next clock edge, whatever the enables are. This also holds in a cycle where software writes the register.
- R3: `ack` is high in a cycle exactly when three conditions hold in that cycle: the master enable is set, at least one request is both flagged and enabled, and `stk_ptr` is below `STACK_DEPTH`.
- R4: While `stk_ptr` equals `STACK_DEPTH`, no acknowledge is given. A pending enabled request is acknowledged in the first cycle the pointer drops below the depth.
- R5: When several enabled requests are pending, the lowest source index wins. Index 0 is the external source, and timers follow in index order. `ack_sel` is one-hot on the winner during `ack` and zero otherwise.
- R6: At the edge that ends an acknowledge cycle, the master enable and the served source's flag are cleared, and the other flags are kept. A new event on the served source in that same cycle sets its flag again. A register write in that same cycle cannot keep the master enable set.
- R7: While the master enable is clear, requests latch but are not acknowledged. Writing the master enable back to 1 inside a service routine allows a nested acknowledge.
- R8: `wake` is high exactly when some request is both flagged and enabled. It does not depend on the master enable or the stack pointer.
- R9: Register layout, for both `reg_wdata` and `reg_rdata`:
  - bit 0 is the master enable;
  - bits 1..NSRC are the source enables, with bit 1 for the external source;
  - bits NSRC+1..2*NSRC are the request flags, with bit NSRC+1 for the external source.
  
  A write with `reg_we` loads all fields at the next edge, subject to R2 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | NSRC | Request pulses; bit 0 is the external source, higher bits are the timers |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 2*NSRC+1 | Control register write data |
| reg_rdata | output | 2*NSRC+1 | Control register contents |
| stk_ptr | input | $clog2(STACK_DEPTH+1) | Current return stack depth |
| ack | output | 1 | Interrupt acknowledge, one cycle |
| ack_sel | output | NSRC | One-hot winning source during `ack` |
| wake | output | 1 | Wake-up request for halt mode |

## Verification
Each piece of state in this block can be read at the ports in the cycle after it changes: the flags and enables through `reg_rdata`, and their combination through `wake` and `ack`. A lost or stuck flag therefore shows within one cycle as a `reg_rdata` mismatch, or as a missing or extra `ack`. A master enable that is not dropped on acknowledge would show as a second `ack` in the very next cycle while other requests are pending. A wrong stack-full comparison shows as an `ack` in a cycle driven with a full pointer. A priority error shows in `ack_sel` whenever two enabled sources are pending together.

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int NTMR = 2,
  parameter int STACK_DEPTH = 2,
  localparam int NSRC = NTMR + 1,
  localparam int CW = 2 * NSRC + 1,
  localparam int SPW = $clog2(STACK_DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_evt,
  input  logic            reg_we,
  input  logic [CW-1:0]   reg_wdata,
  output logic [CW-1:0]   reg_rdata,
  input  logic [SPW-1:0]  stk_ptr,
  output logic            ack,
  output logic [NSRC-1:0] ack_sel,
  output logic            wake
);

  logic            mie;
  logic [NSRC-1:0] en, fl, pend, first;
  logic            room;

  assign pend  = fl & en;
  assign first = pend & (~pend + NSRC'(1));
  assign room  = stk_ptr < SPW'(STACK_DEPTH);
  assign ack   = mie & (|pend) & room;
  assign ack_sel = ack ? first : '0;
  assign wake  = |pend;
  assign reg_rdata = {fl, en, mie};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mie <= 1'b0;
      en  <= '0;
      fl  <= '0;
    end else begin
      if (ack)         mie <= 1'b0;
      else if (reg_we) mie <= reg_wdata[0];
      if (reg_we) en <= reg_wdata[NSRC:1];
      fl <= ((reg_we ? reg_wdata[2*NSRC:NSRC+1] : fl) & ~ack_sel) | src_evt;
    end
  end

  assert_full_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_ptr >= SPW'(STACK_DEPTH)) |-> !ack);

  assert_onehot_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_sel) && (ack == (ack_sel != '0)));

  assert_mie_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !reg_rdata[0]);

  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> ((fl & $past(ack_sel & ~src_evt)) == '0));

  assert_evt_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_evt) |=> ((fl & $past(src_evt)) == $past(src_evt)));

  assert_ack_wakes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> wake);

endmodule

// File: tb/irq_gate_bench.sv
`timescale 1ns/1ps
module irq_gate_bench;
  localparam int NTMR = 2;
  localparam int D = 2;
  localparam int NSRC = NTMR + 1;
  localparam int CW = 2 * NSRC + 1;
  localparam int SPW = $clog2(D + 1);

  logic clk = 0, rst_n = 0, reg_we = 0, ack, wake;
  logic [NSRC-1:0] src_evt = '0, ack_sel;
  logic [CW-1:0] reg_wdata = '0, reg_rdata;
  logic [SPW-1:0] stk_ptr = '0;
  int tests = 0, fails = 0;
  bit done = 0;
  logic m_mie;
  logic [NSRC-1:0] m_en, m_fl;

  always #4 clk = ~clk;

  irq_gate #(.NTMR(NTMR), .STACK_DEPTH(D)) u_irq_gate (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stk_ptr(stk_ptr),
    .ack(ack), .ack_sel(ack_sel), .wake(wake));

  function automatic logic [NSRC-1:0] lowest(input logic [NSRC-1:0] v);
    for (int i = 0; i < NSRC; i++) if (v[i]) return NSRC'(1) << i;
    return '0;
  endfunction

  task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [NSRC-1:0] evt, input logic we,
                      input logic [CW-1:0] wd, input logic [SPW-1:0] sp);
    logic [NSRC-1:0] pend, esel, nfl;
    logic ea, nmie;
    @(negedge clk);
    src_evt = evt; reg_we = we; reg_wdata = wd; stk_ptr = sp;
    #1;
    pend = m_fl & m_en;
    ea = m_mie && pend != '0 && int'(sp) < D;
    esel = ea ? lowest(pend) : '0;
    chk(int'(sp) >= D ? "R4 ack" : (m_mie ? "R3 ack" : "R7 ack"), CW'(ack), CW'(ea));
    chk("R5 ack_sel", CW'(ack_sel), CW'(esel));
    chk("R8 wake", CW'(wake), CW'(pend != '0));
    chk("R9 rdata", reg_rdata, {m_fl, m_en, m_mie});
    nmie = ea ? 1'b0 : (we ? wd[0] : m_mie);
    nfl = ((we ? wd[2*NSRC:NSRC+1] : m_fl) & ~esel) | evt;
    @(posedge clk);
    m_mie = nmie;
    if (we) m_en = wd[NSRC:1];
    m_fl = nfl;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    m_mie = 0; m_en = '0; m_fl = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 rdata", reg_rdata, '0);
    chk("R1 ack", CW'(ack), '0);
    chk("R1 wake", CW'({ack_sel, wake}), '0);
    rst_n = 1;
    // R5/R6: all enabled, all requested at once, external first
    step('0, 1, {{NSRC{1'b0}}, {NSRC{1'b1}}, 1'b1}, '0);
    step('1, 0, '0, '0);
    step('0, 0, '0, '0);
    // R7: master enable now clear, new request latches, no ack
    step('0, 0, '0, '0);
    step('0, 1, {m_fl, m_en, 1'b1}, 1);
    step('0, 0, '0, 1);
    // R4: stack full blocks, wake still high (R8)
    step('0, 1, {m_fl, m_en, 1'b1}, SPW'(D));
    step('0, 0, '0, SPW'(D));
    step('0, 0, '0, SPW'(D - 1));
    // R6: event on served source in ack cycle re-sets flag; write cannot keep mie
    step('0, 1, {NSRC'(1), m_en, 1'b1}, '0);
    step(NSRC'(1), 1, {NSRC'(1), m_en, 1'b1}, '0);
    step('0, 0, '0, '0);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [NSRC-1:0] e;
      logic w;
      logic [CW-1:0] d;
      e = ($urandom % 4 == 0) ? NSRC'($urandom) : '0;
      w = ($urandom % 5 == 0);
      d = CW'($urandom);
      if (w && $urandom % 2 == 0) d[2*NSRC:NSRC+1] = m_fl;
      step(e, w, d, SPW'($urandom % (D + 1)));
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule